// File: doc/BRIEF.md
# Dual-Byte Gated Three-State Buffer

This block is the functional datapath of a two-lane, non-inverting, three-state line buffer. Lanes A and B are independent. Each carries a 9-bit data word from its input port to its output port. Each lane has two active-low gate inputs, and the lane drives its outputs only while both of its gates are held low. Otherwise every bit of that lane is released to high impedance. Because the block is modelled at register-transfer level, each output lane is presented as a value vector plus a per-bit drive vector. A drive bit of 1 means the pin is driven with the value bit. A drive bit of 0 means the pin floats, and in that case the value bit is forced to 0.

A lane must not drive at power-up, even when its gates are already low. The block models power-up with a synchronous active-low reset. Reset places each lane in a hold state. A lane leaves the hold state only after its gate pair has been sampled inactive on a rising clock edge. From then on, the lane drives as soon as both gates are low. For each lane, the effective active-high enable is brought out as a port, so a neighbouring test-access block can observe it. The data path itself has no clock and no register: value and drive follow the inputs within the same cycle.

Top module: `dual_byte_buffer`

## Requirements
- R1: While a lane's effective enable is 1, all 9 of its drive bits are 1 and its value output equals its data input bit for bit, with no inversion.
- R2: If either active-low gate of a lane is 1, that lane's drive bits are all 0 and its value bits are all 0.
- R3: On the first rising edge after reset is released, and on every edge after it, both lanes stay undriven until each lane's own gate pair has been sampled inactive. This holds even if the gates are held low throughout.
- R4: Suppose a lane's gate pair was seen inactive on a rising clock edge with reset high. Then in the next cycle the lane drives as soon as both of its gates are 0.
- R5: The hold state of lane A and the hold state of lane B clear independently. Releasing one lane leaves the other lane undriven.
- R6: Each lane's exported enable (`a_oe`, `b_oe`) equals that lane's drive bits, and within a lane the drive bits are never mixed.
- R7: Asserting reset while a lane is driving re-arms the hold state. After release, the lane stays undriven until its gates are again seen inactive.
- R8: Once a lane is enabled, a change on its data input appears on its value output without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the hold logic |
| rst_n | input | 1 | Synchronous active-low reset (power-up model) |
| a_din | input | 9 | Lane A data input |
| a_en_n | input | 2 | Lane A active-low gate pair |
| b_din | input | 9 | Lane B data input |
| b_en_n | input | 2 | Lane B active-low gate pair |
| a_dout | output | 9 | Lane A output value |
| a_drv | output | 9 | Lane A per-bit drive (1 = driven, 0 = high impedance) |
| b_dout | output | 9 | Lane B output value |
| b_drv | output | 9 | Lane B per-bit drive |
| a_oe | output | 1 | Lane A effective active-high enable |
| b_oe | output | 1 | Lane B effective active-high enable |

## Verification
The bench builds the block with its default parameters: 9 data bits and two gates per lane. At these values every gate combination of both lanes can be reached in a few cycles. The random gate stream therefore covers all sixteen joint gate patterns many times. It also releases the hold state of each lane on different cycles, and it places occasional resets both while a lane is driving and while it is still held.

// File: rtl/dbb_pkg.sv
// Package: shared types for the dual-byte gated buffer.
// Assumes: a lane has exactly two hold states after power-up.
package dbb_pkg;

    // Hold state of one lane: held after reset, free once seen idle.
    typedef enum logic {
        LANE_HELD = 1'b0,
        LANE_FREE = 1'b1
    } lane_hold_e;

    // Number of lanes in the block; the top maps them to ports A and B.
    localparam int NUM_LANES = 2;

endpackage

// File: rtl/lane_gate_reduce.sv
// Module: lane_gate_reduce
// Folds a lane's active-low gate inputs into one active-high request.
// Assumes: every gate must be low for the request to be raised.
module lane_gate_reduce #(
    parameter int EN_W = 2
) (
    input  logic [EN_W-1:0] gate_n,
    output logic            req
);

    // Request is high only when no gate is high.
    always_comb begin
        req = ~(|gate_n);
    end

endmodule

// File: rtl/lane_powerup_hold.sv
// Module: lane_powerup_hold
// Keeps a lane blocked after reset until its request is sampled low once.
// Assumes: synchronous active-low reset; request is stable around clk.
module lane_powerup_hold
    import dbb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic free
);

    lane_hold_e state_q;
    lane_hold_e state_d;

    // Next state: leave HELD only on an idle sample; FREE is sticky.
    always_comb begin
        state_d = state_q;
        if (state_q == LANE_HELD && !req) begin
            state_d = LANE_FREE;
        end
    end

    // State register with synchronous reset to HELD.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LANE_HELD;
        end else begin
            state_q <= state_d;
        end
    end

    // Expose the free flag.
    always_comb begin
        free = (state_q == LANE_FREE);
    end

endmodule

// File: rtl/lane_drive_stage.sv
// Module: lane_drive_stage
// Models a three-state output lane as value plus per-bit drive.
// Assumes: an undriven bit reports value 0.
module lane_drive_stage #(
    parameter int DATA_W = 9
) (
    input  logic              oe,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [DATA_W-1:0] drv
);

    // One slice per output bit.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign dout[i] = din[i] & oe;
        assign drv[i]  = oe;
    end

endmodule

// File: rtl/dual_byte_buffer.sv
// Module: dual_byte_buffer (top)
// Two independent non-inverting three-state lanes (A, B), each gated by
// a pair of active-low inputs and blocked after reset until idle is seen.
// Assumes: outputs are modelled as value + drive; test override is external.
module dual_byte_buffer
    import dbb_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int EN_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a_din,
    input  logic [EN_W-1:0]   a_en_n,
    input  logic [DATA_W-1:0] b_din,
    input  logic [EN_W-1:0]   b_en_n,
    output logic [DATA_W-1:0] a_dout,
    output logic [DATA_W-1:0] a_drv,
    output logic [DATA_W-1:0] b_dout,
    output logic [DATA_W-1:0] b_drv,
    output logic              a_oe,
    output logic              b_oe
);

    localparam int NL = NUM_LANES;

    logic [DATA_W-1:0] din_l  [NL];
    logic [EN_W-1:0]   gate_l [NL];
    logic [DATA_W-1:0] dout_l [NL];
    logic [DATA_W-1:0] drv_l  [NL];
    logic [NL-1:0]     req_l;
    logic [NL-1:0]     free_l;
    logic [NL-1:0]     oe_l;

    // Map ports onto lane arrays.
    assign din_l[0]  = a_din;
    assign din_l[1]  = b_din;
    assign gate_l[0] = a_en_n;
    assign gate_l[1] = b_en_n;

    // One fully independent lane per byte.
    for (genvar l = 0; l < NL; l++) begin : g_lane
        lane_gate_reduce #(.EN_W(EN_W)) u_reduce (
            .gate_n (gate_l[l]),
            .req    (req_l[l])
        );

        lane_powerup_hold u_hold (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req_l[l]),
            .free  (free_l[l])
        );

        // Effective enable: requested and released from hold.
        assign oe_l[l] = req_l[l] & free_l[l];

        lane_drive_stage #(.DATA_W(DATA_W)) u_drive (
            .oe   (oe_l[l]),
            .din  (din_l[l]),
            .dout (dout_l[l]),
            .drv  (drv_l[l])
        );
    end

    // Map lane arrays back to ports.
    assign a_dout = dout_l[0];
    assign a_drv  = drv_l[0];
    assign b_dout = dout_l[1];
    assign b_drv  = drv_l[1];
    assign a_oe   = oe_l[0];
    assign b_oe   = oe_l[1];

endmodule

// File: rtl/dual_byte_buffer_chk.sv
// Module: dual_byte_buffer_chk
// Port-level temporal checks for dual_byte_buffer, bound below.
module dual_byte_buffer_chk #(
    parameter int DATA_W = 9,
    parameter int EN_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] a_din,
    input logic [EN_W-1:0]   a_en_n,
    input logic [DATA_W-1:0] b_din,
    input logic [EN_W-1:0]   b_en_n,
    input logic [DATA_W-1:0] a_dout,
    input logic [DATA_W-1:0] a_drv,
    input logic [DATA_W-1:0] b_dout,
    input logic [DATA_W-1:0] b_drv,
    input logic              a_oe,
    input logic              b_oe
);

    assert_a_passes_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
        a_oe |-> (a_dout == a_din && a_drv == {DATA_W{1'b1}}));
    assert_b_passes_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
        b_oe |-> (b_dout == b_din && b_drv == {DATA_W{1'b1}}));

    assert_a_gate_high_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en_n != '0) |-> (a_drv == '0 && a_dout == '0));
    assert_b_gate_high_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (b_en_n != '0) |-> (b_drv == '0 && b_dout == '0));

    assert_held_after_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!a_oe && !b_oe));

    assert_a_opens_after_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(a_en_n != '0) && a_en_n == '0) |-> a_oe);
    assert_b_opens_after_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(b_en_n != '0) && b_en_n == '0) |-> b_oe);

    assert_a_drive_uniform_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_drv == '0 || a_drv == '1) && (a_oe == a_drv[0]));
    assert_b_drive_uniform_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (b_drv == '0 || b_drv == '1) && (b_oe == b_drv[0]));

endmodule

bind dual_byte_buffer dual_byte_buffer_chk #(.DATA_W(DATA_W), .EN_W(EN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .a_din(a_din), .a_en_n(a_en_n),
    .b_din(b_din), .b_en_n(b_en_n), .a_dout(a_dout), .a_drv(a_drv),
    .b_dout(b_dout), .b_drv(b_drv), .a_oe(a_oe), .b_oe(b_oe)
);

// File: tb/sim_dual_byte_buffer.sv
// Bench for dual_byte_buffer: directed corners plus seeded random stimulus.
module sim_dual_byte_buffer;

    localparam int DW = 9;
    localparam int EW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] a_din, b_din;
    logic [EW-1:0] a_en_n, b_en_n;
    logic [DW-1:0] a_dout, a_drv, b_dout, b_drv;
    logic          a_oe, b_oe;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done     = 1'b0;
    bit  a_held   = 1'b1;
    bit  b_held   = 1'b1;

    always #2.5 clk = ~clk;

    dual_byte_buffer #(.DATA_W(DW), .EN_W(EW)) u0 (
        .clk(clk), .rst_n(rst_n), .a_din(a_din), .a_en_n(a_en_n),
        .b_din(b_din), .b_en_n(b_en_n), .a_dout(a_dout), .a_drv(a_drv),
        .b_dout(b_dout), .b_drv(b_drv), .a_oe(a_oe), .b_oe(b_oe)
    );

    // Reference hold model, from R3/R4/R7.
    always @(posedge clk) begin
        if (!rst_n) begin
            a_held = 1'b1;
            b_held = 1'b1;
        end else begin
            if (a_en_n != '0) a_held = 1'b0;
            if (b_en_n != '0) b_held = 1'b0;
        end
    end

    function automatic logic exp_oe(input logic [EW-1:0] g, input bit held);
        return (g == '0) && !held;
    endfunction

    function automatic logic [DW-1:0] exp_val(input logic [DW-1:0] d, input logic oe);
        return oe ? d : '0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the reference model.
    task automatic check_all(input string tag);
        logic ea, eb;
        ea = exp_oe(a_en_n, a_held);
        eb = exp_oe(b_en_n, b_held);
        check({tag, " a_oe"},   32'(a_oe),   32'(ea));
        check({tag, " b_oe"},   32'(b_oe),   32'(eb));
        check({tag, " a_drv"},  32'(a_drv),  32'({DW{ea}}));
        check({tag, " b_drv"},  32'(b_drv),  32'({DW{eb}}));
        check({tag, " a_dout"}, 32'(a_dout), 32'(exp_val(a_din, ea)));
        check({tag, " b_dout"}, 32'(b_dout), 32'(exp_val(b_din, eb)));
    endtask

    task automatic drive(input logic r, input logic [EW-1:0] ga, input logic [EW-1:0] gb);
        @(negedge clk);
        rst_n  = r;
        a_en_n = ga;
        b_en_n = gb;
        a_din  = DW'($urandom);
        b_din  = DW'($urandom);
        #1;
    endtask

    initial begin : watchdog
        #(5ns * 20000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd1234));
        rst_n = 1'b0; a_en_n = '0; b_en_n = '0; a_din = '0; b_din = '0;
        repeat (3) drive(1'b0, 2'b00, 2'b00);
        // Reset state after the reset edges: nothing driven (R3).
        check("R3 reset a_drv", 32'(a_drv), 32'h0);
        check("R3 reset b_drv", 32'(b_drv), 32'h0);
        // Gates held low after release: still undriven (R3).
        for (int i = 0; i < 4; i++) begin
            drive(1'b1, 2'b00, 2'b00);
            check("R3 held a_oe", 32'(a_oe), 32'h0);
            check("R3 held b_oe", 32'(b_oe), 32'h0);
        end
        // One gate of B high: B off (R2); idle is sampled at the next edge.
        drive(1'b1, 2'b00, 2'b01);
        check("R2 b_drv one gate high", 32'(b_drv), 32'h0);
        drive(1'b1, 2'b00, 2'b00);
        check("R4 b_oe after idle", 32'(b_oe), 32'h1);
        check("R1 b_dout equals b_din", 32'(b_dout), 32'(b_din));
        check("R1 b_drv all ones", 32'(b_drv), 32'h1ff);
        check("R5 a still held", 32'(a_oe), 32'h0);
        // Release A through the other gate.
        drive(1'b1, 2'b10, 2'b00);
        check("R2 a_dout zero one gate high", 32'(a_dout), 32'h0);
        drive(1'b1, 2'b00, 2'b00);
        check("R4 a_oe after idle", 32'(a_oe), 32'h1);
        check("R6 a_drv tracks a_oe", 32'(a_drv), 32'h1ff);
        // Data change with no clock edge (R8).
        a_din = 9'h155; b_din = 9'h0aa;
        #0.5;
        check("R8 a_dout follows", 32'(a_dout), 32'h155);
        check("R8 b_dout follows", 32'(b_dout), 32'h0aa);
        // Reset while driving re-arms hold (R7).
        drive(1'b0, 2'b00, 2'b00);
        drive(1'b1, 2'b00, 2'b00);
        check("R7 a re-held", 32'(a_oe), 32'h0);
        check("R7 b re-held", 32'(b_oe), 32'h0);
        // Seeded random phase against the model.
        for (int c = 0; c < 3000; c++) begin
            logic r;
            logic [EW-1:0] ga, gb;
            r  = ($urandom_range(99) < 2) ? 1'b0 : 1'b1;
            ga = {($urandom_range(3) == 0), ($urandom_range(3) == 0)};
            gb = {($urandom_range(3) == 0), ($urandom_range(3) == 0)};
            drive(r, ga, gb);
            if (r) check_all("R1 R2 R4 R5 R6 R7 random");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule